// File: doc/BRIEF.md
# JPEG Run-Length Symbol Encoder

This block turns one quantized 8x8 block into the intermediate symbol stream that a JPEG entropy coder consumes. The 64 signed coefficients arrive one at a time in zigzag order. For each symbol the block produces an 8-bit code byte and a right-aligned field of raw bits with its length. The Huffman lookup and the bit packer sit downstream.

The first coefficient of each block is coded as its difference from the DC value of the block before it. The other 63 coefficients are coded as pairs of a zero-run count and a magnitude. Runs of sixteen zeros that come before a nonzero value get their own filler code. Zeros at the tail of a block are replaced by a single end-of-block code. An image-start pulse returns the DC predictor to zero.

The input and the output both use valid/ready handshakes. The output stage holds a symbol for as long as ready is low. While it holds a symbol, or while filler codes still have to go out, the block stops accepting coefficients.

Top module: `rle_sym_encoder`

## Requirements
- R1: The coefficient at zigzag position 0 always produces one symbol. Its code byte has 0 in the upper nibble and the magnitude category of (coefficient - predictor) in the lower nibble. Its raw bits encode that difference. The predictor then becomes this coefficient.
- R2: A nonzero coefficient at positions 1..63 produces a symbol whose code byte has, in its upper nibble, the number of zeros since the previous emitted coefficient (less any full groups of 16 already emitted as filler codes), and the magnitude category in its lower nibble.
- R3: The magnitude category is the number of bits needed for the absolute value. The raw-bit length equals the category and also equals the low nibble of the code byte. Raw bits sit right-aligned in `sym_bits`, with all bits above the length at zero. A positive value is sent as its plain binary.
- R4: A negative value is sent as the ones' complement of its magnitude in category bits. For example, -12 gives length 4 with bits 0011, and -2048 gives length 12 with bits 0x7FF.
- R5: A DC difference of zero gives code 0x00 with length 0.
- R6: Before a nonzero coefficient, each full group of 16 zeros in its preceding run is sent as code 0xF0 with length 0, ahead of that coefficient's own symbol.
- R7: If a block ends in zeros, one code 0x00 of length 0 is sent once position 63 is accepted. None of those trailing zeros produces a 0xF0.
- R8: If position 63 is nonzero, the block ends with that coefficient's symbol and no end-of-block code.
- R9: A pulse on `img_start` sets the DC predictor to zero for the next block. Reset does the same.
- R10: While `sym_valid` is high and `sym_ready` is low, the code, length and bits hold steady. Every symbol is delivered exactly once, in order. After reset `sym_valid` is low.
- R11: `coef_ready` is low while a stalled symbol is held. Gaps in `coef_valid` and stalls on `sym_ready` do not change the symbol sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_start | input | 1 | Pulse that clears the DC predictor |
| coef_valid | input | 1 | Coefficient available |
| coef_ready | output | 1 | Coefficient accepted when high with valid |
| coef_data | input | COEF_W | Signed quantized coefficient, zigzag order |
| sym_valid | output | 1 | Symbol available |
| sym_ready | input | 1 | Downstream takes the symbol |
| sym_code | output | 8 | Run/category, filler or end-of-block code |
| sym_len | output | 4 | Number of valid raw bits |
| sym_bits | output | COEF_W+1 | Raw bits, right-aligned |

## Verification
A wrong zigzag position counter shows at the ports within one block: a DC symbol appears in the middle of the AC symbols, or the end-of-block code goes missing or comes twice. A drifting run counter changes the upper nibble of the next nonzero symbol or the number of 0xF0 codes, so it is visible at the first nonzero after the fault. A stale predictor shows in the DC symbol of the next block. A leaking output register shows up the first time `sym_ready` is held low.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam int BLK_LEN  = 64;
    localparam int IDX_W    = $clog2(BLK_LEN);
    localparam int RUN_SPAN = 16;
    localparam int LEN_W    = 4;

    localparam logic [7:0] ZRL_CODE = 8'hF0;
    localparam logic [7:0] EOB_CODE = 8'h00;

    typedef enum logic [1:0] {
        SYM_DC,
        SYM_AC,
        SYM_ZRL,
        SYM_EOB
    } sym_kind_e;

    typedef enum logic [1:0] {
        RUN_KEEP,
        RUN_CLEAR,
        RUN_INC,
        RUN_DROP
    } run_cmd_e;

    typedef struct packed {
        logic [7:0]       code;
        logic [LEN_W-1:0] len;
    } sym_hdr_t;

    function automatic sym_hdr_t make_hdr(sym_kind_e kind, logic [3:0] run,
                                          logic [LEN_W-1:0] cat);
        sym_hdr_t h;
        unique case (kind)
            SYM_DC:  begin h.code = {4'h0, cat[3:0]}; h.len = cat; end
            SYM_AC:  begin h.code = {run, cat[3:0]};  h.len = cat; end
            SYM_ZRL: begin h.code = ZRL_CODE;         h.len = '0;  end
            default: begin h.code = EOB_CODE;         h.len = '0;  end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/rle_magnitude.sv
module rle_magnitude
    import rle_pkg::*;
#(
    parameter int W = 13
) (
    input  logic signed [W-1:0] value,
    output logic [LEN_W-1:0]    cat,
    output logic [W-1:0]        raw
);
    logic [W-1:0] mag;
    logic [W-1:0] body;
    logic [W-1:0] mask;

    always_comb begin
        mag = value[W-1] ? W'(-value) : W'(value);
        cat = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) cat = LEN_W'(i + 1);
        end
        // negative: value-1 in two's complement is ones' complement of |value|
        body = value[W-1] ? W'(value - W'(1)) : W'(value);
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(cat));
        end
        raw = body & mask;
    end

endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
    import rle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  run_cmd_e         cmd,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] run,
    output logic             first_pos,
    output logic             last_pos,
    output logic             run_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            run <= '0;
        end else begin
            if (advance) idx <= idx + 1'b1;
            unique case (cmd)
                RUN_CLEAR: run <= '0;
                RUN_INC:   run <= run + 1'b1;
                RUN_DROP:  run <= run - IDX_W'(RUN_SPAN);
                default:   run <= run;
            endcase
        end
    end

    assign first_pos = (idx == '0);
    assign last_pos  = (idx == IDX_W'(BLK_LEN - 1));
    assign run_full  = (run >= IDX_W'(RUN_SPAN));

    // position wraps to the DC slot after the last coefficient
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        advance && last_pos |=> first_pos);

endmodule

// File: rtl/rle_out_stage.sv
module rle_out_stage
    import rle_pkg::*;
#(
    parameter int BITS_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  sym_hdr_t          hdr_in,
    input  logic [BITS_W-1:0] bits_in,
    input  logic              sym_ready,
    output logic              slot_free,
    output logic              sym_valid,
    output sym_hdr_t          hdr_out,
    output logic [BITS_W-1:0] bits_out
);
    assign slot_free = !sym_valid || sym_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            hdr_out   <= '0;
            bits_out  <= '0;
        end else begin
            if (load) begin
                sym_valid <= 1'b1;
                hdr_out   <= hdr_in;
                bits_out  <= bits_in;
            end else if (sym_ready) begin
                sym_valid <= 1'b0;
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        sym_valid && !sym_ready |=> sym_valid && $stable(hdr_out) && $stable(bits_out));

    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> slot_free);

endmodule

// File: rtl/rle_sym_encoder.sv
module rle_sym_encoder
    import rle_pkg::*;
#(
    parameter int COEF_W = 12,
    localparam int DIFF_W = COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     img_start,
    input  logic                     coef_valid,
    output logic                     coef_ready,
    input  logic signed [COEF_W-1:0] coef_data,
    output logic                     sym_valid,
    input  logic                     sym_ready,
    output logic [7:0]               sym_code,
    output logic [LEN_W-1:0]         sym_len,
    output logic [DIFF_W-1:0]        sym_bits
);
    logic signed [COEF_W-1:0] prev_dc;
    logic signed [COEF_W-1:0] pend_val;
    logic                     pend;

    logic                     slot_free;
    logic                     accept;
    logic                     cur_zero;
    logic signed [COEF_W-1:0] pred;
    logic signed [DIFF_W-1:0] mag_in;
    logic [LEN_W-1:0]         cat;
    logic [DIFF_W-1:0]        raw;

    logic [IDX_W-1:0]         idx;
    logic [IDX_W-1:0]         run;
    logic                     first_pos;
    logic                     last_pos;
    logic                     run_full;

    logic                     load;
    sym_kind_e                kind;
    run_cmd_e                 run_cmd;
    logic                     pend_set;
    logic                     pend_clr;
    sym_hdr_t                 hdr_in;
    sym_hdr_t                 hdr_out;
    logic [DIFF_W-1:0]        bits_in;

    assign coef_ready = slot_free && !pend;
    assign accept     = coef_valid && coef_ready;
    assign cur_zero   = (coef_data == '0);
    assign pred       = img_start ? '0 : prev_dc;

    always_comb begin
        if (pend)
            mag_in = DIFF_W'(pend_val);
        else if (first_pos)
            mag_in = DIFF_W'(coef_data) - DIFF_W'(pred);
        else
            mag_in = DIFF_W'(coef_data);
    end

    rle_magnitude #(.W(DIFF_W)) u_mag (
        .value (mag_in),
        .cat   (cat),
        .raw   (raw)
    );

    rle_run_tracker u_run (
        .clk       (clk),
        .rst       (rst),
        .advance   (accept),
        .cmd       (run_cmd),
        .idx       (idx),
        .run       (run),
        .first_pos (first_pos),
        .last_pos  (last_pos),
        .run_full  (run_full)
    );

    always_comb begin
        load     = 1'b0;
        kind     = SYM_AC;
        run_cmd  = RUN_KEEP;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        if (pend) begin
            if (slot_free) begin
                load = 1'b1;
                if (run_full) begin
                    kind    = SYM_ZRL;
                    run_cmd = RUN_DROP;
                end else begin
                    kind     = SYM_AC;
                    run_cmd  = RUN_CLEAR;
                    pend_clr = 1'b1;
                end
            end
        end else if (accept) begin
            if (first_pos) begin
                load    = 1'b1;
                kind    = SYM_DC;
                run_cmd = RUN_CLEAR;
            end else if (cur_zero) begin
                if (last_pos) begin
                    load    = 1'b1;
                    kind    = SYM_EOB;
                    run_cmd = RUN_CLEAR;
                end else begin
                    run_cmd = RUN_INC;
                end
            end else if (run_full) begin
                load     = 1'b1;
                kind     = SYM_ZRL;
                run_cmd  = RUN_DROP;
                pend_set = 1'b1;
            end else begin
                load    = 1'b1;
                kind    = SYM_AC;
                run_cmd = RUN_CLEAR;
            end
        end
    end

    assign hdr_in  = make_hdr(kind, run[3:0], cat);
    assign bits_in = (kind == SYM_DC || kind == SYM_AC) ? raw : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_dc  <= '0;
            pend     <= 1'b0;
            pend_val <= '0;
        end else begin
            if (img_start) prev_dc <= '0;
            if (accept && first_pos) prev_dc <= coef_data;
            if (pend_set) begin
                pend     <= 1'b1;
                pend_val <= coef_data;
            end else if (pend_clr) begin
                pend <= 1'b0;
            end
        end
    end

    rle_out_stage #(.BITS_W(DIFF_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .hdr_in    (hdr_in),
        .bits_in   (bits_in),
        .sym_ready (sym_ready),
        .slot_free (slot_free),
        .sym_valid (sym_valid),
        .hdr_out   (hdr_out),
        .bits_out  (sym_bits)
    );

    assign sym_code = hdr_out.code;
    assign sym_len  = hdr_out.len;

    p_code_len_r3: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> sym_code[3:0] == sym_len);

    p_bits_fit_r3: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (sym_bits >> sym_len) == '0);

    p_stall_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        sym_valid && !sym_ready |-> !coef_ready);

    p_pred_clear_r9: assert property (@(posedge clk) disable iff (rst)
        img_start && !(accept && first_pos) |=> prev_dc == '0);

endmodule

// File: tb/tb_rle_sym_encoder.sv
module tb_rle_sym_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int COEF_W = 12;
    localparam int DIFF_W = COEF_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic img_start = 1'b0;
    logic coef_valid = 1'b0;
    logic coef_ready;
    logic signed [COEF_W-1:0] coef_data = '0;
    logic sym_valid;
    logic sym_ready = 1'b1;
    logic [7:0] sym_code;
    logic [3:0] sym_len;
    logic [DIFF_W-1:0] sym_bits;

    int checks = 0;
    int failures = 0;
    int tb_pred = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int stalls_seen = 0;
    int hold_errs = 0;
    bit finished = 1'b0;

    logic [24:0] exp_q[$];
    logic [24:0] got_q[$];
    logic [24:0] held;
    bit was_stalled = 1'b0;

    rle_sym_encoder #(.COEF_W(COEF_W)) dut (
        .clk(clk), .rst(rst), .img_start(img_start),
        .coef_valid(coef_valid), .coef_ready(coef_ready), .coef_data(coef_data),
        .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_code(sym_code), .sym_len(sym_len), .sym_bits(sym_bits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [24:0] pack(int code, int len, int bits);
        return {8'(code), 4'(len), 13'(bits)};
    endfunction

    function automatic int cat_of(int v);
        int m = (v < 0) ? -v : v;
        int c = 0;
        while (m > 0) begin c++; m = m >> 1; end
        return c;
    endfunction

    function automatic int raw_of(int v);
        int c = cat_of(v);
        if (v >= 0) return v;
        return ((1 << c) - 1) - (-v);
    endfunction

    task automatic check(bit ok, string tag, string what, logic [24:0] got, logic [24:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // expected symbols per R1..R8
    task automatic build_expected(int c[64]);
        int d, run, lastnz;
        exp_q.delete();
        d = c[0] - tb_pred;
        exp_q.push_back(pack(cat_of(d), cat_of(d), raw_of(d)));
        lastnz = 0;
        for (int k = 1; k < 64; k++) if (c[k] != 0) lastnz = k;
        run = 0;
        for (int k = 1; k < 64; k++) begin
            if (c[k] == 0) run++;
            else begin
                while (run >= 16) begin exp_q.push_back(pack(8'hF0, 0, 0)); run -= 16; end
                exp_q.push_back(pack(run * 16 + cat_of(c[k]), cat_of(c[k]), raw_of(c[k])));
                run = 0;
            end
        end
        if (lastnz < 63) exp_q.push_back(pack(8'h00, 0, 0));
        tb_pred = c[0];
    endtask

    task automatic send_block(int c[64], int gap);
        for (int k = 0; k < 64; k++) begin
            coef_data = COEF_W'(c[k]);
            coef_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (coef_ready) break;
            end
            @(posedge clk); #1;
            if (gap > 0 && (k % 3) == 1) begin
                coef_valid = 1'b0;
                repeat (gap) @(posedge clk);
                #1;
            end
        end
        coef_valid = 1'b0;
    endtask

    task automatic run_block(string name, string tag, int c[64], int gap);
        int cyc = 0;
        build_expected(c);
        got_q.delete();
        send_block(c, gap);
        while (got_q.size() < exp_q.size() && cyc < 2000) begin
            @(posedge clk); #1; cyc++;
        end
        repeat (6) @(posedge clk);
        #1;
        check(got_q.size() == exp_q.size(), tag, {name, " symbol count"},
              25'(got_q.size()), 25'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], tag, $sformatf("%s symbol %0d", name, i), got_q[i], exp_q[i]);
    endtask

    task automatic pulse_img();
        @(posedge clk); #1 img_start = 1'b1;
        @(posedge clk); #1 img_start = 1'b0;
        tb_pred = 0;
    endtask

    // collect symbols and watch stall behaviour (R10, R11)
    always @(negedge clk) begin
        if (!rst) begin
            if (was_stalled) begin
                if (!sym_valid || {sym_code, sym_len, sym_bits} != held) hold_errs++;
            end
            if (sym_valid && !sym_ready) begin
                stalls_seen++;
                if (coef_ready) hold_errs++;
                was_stalled = 1'b1;
                held = {sym_code, sym_len, sym_bits};
            end else begin
                was_stalled = 1'b0;
            end
            if (sym_valid && sym_ready) got_q.push_back({sym_code, sym_len, sym_bits});
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sym_ready = stall_mode ? lfsr[0] : 1'b1;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // R1 R2 R3 R4 R7: mixed block, trailing zeros
    task automatic t_basic(int gap);
        int b[64];
        foreach (b[i]) b[i] = 0;
        b[0] = 20; b[1] = 9; b[4] = 3; b[5] = -5; b[9] = -1; b[10] = -12;
        run_block("basic", "R2", b, gap);
    endtask

    // R5 R6: zero DC difference and two groups of filler codes
    task automatic t_zrl(int gap);
        int b[64];
        foreach (b[i]) b[i] = 0;
        b[0] = 20; b[18] = 7; b[55] = -3;
        run_block("zrl", "R6", b, gap);
    endtask

    // R8: last position nonzero, no end-of-block
    task automatic t_last();
        int b[64];
        foreach (b[i]) b[i] = 0;
        b[0] = -100; b[63] = 1;
        run_block("last_nonzero", "R8", b, 0);
    endtask

    // R7: all AC zero gives only the end-of-block code
    task automatic t_allzero();
        int b[64];
        foreach (b[i]) b[i] = 0;
        run_block("all_zero", "R7", b, 0);
    endtask

    // R9: predictor cleared by img_start
    task automatic t_img();
        int b[64];
        foreach (b[i]) b[i] = 0;
        b[0] = 5;
        pulse_img();
        run_block("img_start", "R9", b, 0);
        check(exp_q.size() > 0 && exp_q[0] == pack(8'h03, 3, 5), "R9", "expected DC 0x03/101",
              exp_q[0], pack(8'h03, 3, 5));
    endtask

    // R3 R4: extreme magnitudes
    task automatic t_extreme();
        int b[64];
        pulse_img();
        foreach (b[i]) b[i] = 0;
        b[0] = -2048; b[1] = 2047; b[2] = -2048;
        run_block("extreme_a", "R4", b, 0);
        foreach (b[i]) b[i] = 0;
        b[0] = 2047;
        run_block("extreme_b", "R3", b, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(sym_valid == 1'b0, "R10", "sym_valid after reset", 25'(sym_valid), 25'(0));
        check(coef_ready == 1'b1, "R11", "coef_ready after reset", 25'(coef_ready), 25'(1));
        @(posedge clk); #1;
        t_basic(0);
        t_zrl(0);
        t_last();
        t_allzero();
        t_img();
        t_extreme();
        // R10 R11: same blocks under output stalls and input gaps
        stall_mode = 1'b1;
        pulse_img();
        t_basic(2);
        t_zrl(1);
        t_last();
        stall_mode = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(stalls_seen > 0, "R10", "stalls exercised", 25'(stalls_seen), 25'(1));
        check(hold_errs == 0, "R11", "hold/ready violations", 25'(hold_errs), 25'(0));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule